// File: doc/BRIEF.md
# Ring Beacon Timeout Monitor

This block watches a beacon-based ring redundancy protocol from the position of an ordinary ring member with two ring ports. A frame parser upstream delivers, for each port, a one-cycle pulse whenever a beacon arrives. With the pulse come the ring status carried in that beacon (normal or fault) and the beacon timeout value in microseconds. From these inputs the block keeps a three-state view of the ring: idle, fault or normal.

The first beacon seen after reset moves the ring from idle to fault. It also latches the timeout, converted to 10 µs ticks, and starts one down-counting watchdog per port. Each later beacon on a port reloads that port's watchdog. When a watchdog runs out, the block records a beacon-lost event for that port. If the ring was normal at that moment, it also drops the ring back to fault.

All events are collected in a sticky register that the host clears by writing ones. Each port has its own interrupt pulse. A free-running prescaler divides the system clock down to the 10 µs tick.

Top module: `ring_beacon_monitor`

## Requirements
- R1: After the synchronous reset `rst`, `ring_state` is idle (encoding 0 = idle, 1 = fault, 2 = normal), `events` is zero, `timer_run` is zero and `irq` is zero.
- R2: While idle, a beacon on any port moves `ring_state` to fault one cycle later. It sets event bit 1 (fault transition) and starts both port timers, so `timer_run` becomes 2'b11.
- R3: In fault, a beacon whose status is normal (`bcn_normal`=1) moves the state to normal and sets event bit 0 (normal transition). In normal, a beacon with fault status moves the state to fault and sets event bit 1.
- R4: Every beacon on a port reloads that port's timer with the latched timeout. Beacons that arrive within the timeout never let the timer expire.
- R5: The latched timeout in ticks is floor(microseconds / 10), raised to 20 ticks (200 µs) when smaller. The value is latched only on the idle-to-fault beacon. A timer expires after that many ticks, and one tick is `TICK_DIV` clock cycles.
- R6: When port p's timer expires, `timer_run[p]` clears and event bit 6+p (beacon lost on port p) sets. If the state was normal, it becomes fault and event bit 1 sets. An expiry that leaves no timer running sets event bit 2 (both timers stopped).
- R7: Event bits 3 and 4 record the first beacon on port 0 and on port 1 since leaving idle. All event bits are sticky and are cleared by writing 1 to the matching bit of `ev_clr`. A bit that is set and cleared in the same cycle stays set.
- R8: `irq[p]` pulses for one cycle when port p's timer expires, or when a beacon on port p changes the ring state.
- R9: A `ring_rst` pulse returns the monitor to idle, stops both timers and leaves `events` with only bit 5 (reset) set.
- R10: While `en` is low, the state is held idle, the timers are stopped, `events` is zero and beacons are ignored.
- R11: When both ports deliver a beacon in the same cycle, port 0's status and timeout decide the state change and the latched timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Monitor enable; low holds idle |
| ring_rst | input | 1 | One-cycle pulse that restarts the monitor |
| bcn_vld | input | 2 | Per-port beacon received pulse |
| bcn_normal | input | 2 | Per-port ring status from the beacon, 1 = normal |
| bcn_tmo_p0 | input | 16 | Beacon timeout in µs carried on port 0 |
| bcn_tmo_p1 | input | 16 | Beacon timeout in µs carried on port 1 |
| ev_clr | input | 8 | Write-one-to-clear mask for the event bits |
| ring_state | output | 2 | Ring state: 0 idle, 1 fault, 2 normal |
| events | output | 8 | Sticky event bits |
| timer_run | output | 2 | Per-port timer running |
| irq | output | 2 | Per-port interrupt pulse |

## Verification
Some properties are checked on every cycle by assertions. A running timer never holds zero, and an expiry always stops its timer. The idle state never coexists with a running timer. Normal is entered only from fault, and disabling forces idle.

Other behaviours need the bench's scenarios and its per-cycle reference model. These are the tick-exact expiry window and the rounding and clamping of the timeout. They also include priority when beacons arrive together, sticky clearing that loses to a same-cycle set, and the interrupt that follows expiry.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

    localparam int NUM_PORTS = 2;
    localparam int US_W      = 16;
    localparam int TICK_W    = 16;
    localparam int EV_W      = 8;
    localparam int TICK_US   = 10;
    localparam int MIN_TICKS = 20;

    localparam int EV_NORM   = 0;
    localparam int EV_FAULT  = 1;
    localparam int EV_STOP   = 2;
    localparam int EV_FIRST0 = 3;
    localparam int EV_RESET  = 5;
    localparam int EV_LOST0  = 6;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_FAULT  = 2'd1,
        RS_NORMAL = 2'd2
    } ring_st_e;

    typedef struct packed {
        logic            vld;
        logic            normal;
        logic [US_W-1:0] tmo_us;
    } beacon_t;

    function automatic logic [TICK_W-1:0] us_to_ticks(input logic [US_W-1:0] us);
        logic [US_W-1:0] q;
        q = us / US_W'(TICK_US);
        if (q < US_W'(MIN_TICKS))
            q = US_W'(MIN_TICKS);
        return TICK_W'(q);
    endfunction

endpackage

// File: rtl/rbm_tick_gen.sv
module rbm_tick_gen #(
    parameter int TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            div_q <= '0;
        else if (tick)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (rst)
        div_q <= LAST); // R5

endmodule

// File: rtl/rbm_port_timer.sv
module rbm_port_timer
    import rbm_pkg::*;
#(
    parameter int DEF_TICKS = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              tick,
    input  logic              load,
    input  logic [TICK_W-1:0] load_val,
    output logic              running,
    output logic              expire
);
    logic [TICK_W-1:0] cnt_q;

    assign expire = running && tick && (cnt_q == TICK_W'(1)) && !load && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q   <= TICK_W'(DEF_TICKS);
            running <= 1'b0;
        end else if (load) begin
            cnt_q   <= load_val;
            running <= 1'b1;
        end else if (running && tick) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == TICK_W'(1))
                running <= 1'b0;
        end
    end

    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt_q != '0)); // R5

    AST_EXPIRE_STOPS: assert property (@(posedge clk) disable iff (rst)
        expire |=> !running); // R6

endmodule

// File: rtl/rbm_ring_fsm.sv
module rbm_ring_fsm
    import rbm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 ring_rst,
    input  beacon_t              bcn [NUM_PORTS],
    input  logic [EV_W-1:0]      ev_clr,
    input  logic [NUM_PORTS-1:0] run,
    input  logic [NUM_PORTS-1:0] expire,
    output logic [NUM_PORTS-1:0] load,
    output logic [TICK_W-1:0]    load_val,
    output logic                 tmr_clr,
    output ring_st_e             state,
    output logic [EV_W-1:0]      events,
    output logic [NUM_PORTS-1:0] irq
);
    logic [TICK_W-1:0]    tmo_q, tmo_d;
    logic [NUM_PORTS-1:0] seen_q;
    logic [NUM_PORTS-1:0] irq_d;
    logic [NUM_PORTS-1:0] vld_vec;
    logic [NUM_PORTS-1:0] run_nxt;
    logic [EV_W-1:0]      ev_set;
    ring_st_e             st_bcn, st_d;
    logic                 lead_vld, lead_idx;
    beacon_t              lead;

    assign tmr_clr = !en || ring_rst;

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++)
            vld_vec[p] = bcn[p].vld;
    end

    always_comb begin
        lead_vld = |vld_vec;
        lead_idx = !vld_vec[0];
        lead     = bcn[lead_idx];
        st_bcn   = state;
        tmo_d    = tmo_q;
        ev_set   = '0;
        load     = '0;

        if (lead_vld) begin
            unique case (state)
                RS_IDLE: begin
                    st_bcn           = RS_FAULT;
                    tmo_d            = us_to_ticks(lead.tmo_us);
                    load             = '1;
                    ev_set[EV_FAULT] = 1'b1;
                end
                RS_FAULT: if (lead.normal) begin
                    st_bcn          = RS_NORMAL;
                    ev_set[EV_NORM] = 1'b1;
                end
                RS_NORMAL: if (!lead.normal) begin
                    st_bcn           = RS_FAULT;
                    ev_set[EV_FAULT] = 1'b1;
                end
                default: st_bcn = RS_IDLE;
            endcase
        end
        if (state != RS_IDLE)
            load = vld_vec;
        if (tmr_clr)
            load = '0;
        load_val = tmo_d;

        irq_d = '0;
        if (st_bcn != state)
            irq_d[lead_idx] = 1'b1;
        irq_d = irq_d | expire;

        st_d = st_bcn;
        if ((|expire) && state == RS_NORMAL) begin
            st_d             = RS_FAULT;
            ev_set[EV_FAULT] = 1'b1;
        end

        run_nxt = (run & ~expire) | load;
        if ((|expire) && run_nxt == '0)
            ev_set[EV_STOP] = 1'b1;

        for (int p = 0; p < NUM_PORTS; p++) begin
            ev_set[EV_LOST0 + p]  = expire[p];
            ev_set[EV_FIRST0 + p] = vld_vec[p] && !seen_q[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state  <= RS_IDLE;
            tmo_q  <= TICK_W'(MIN_TICKS);
            seen_q <= '0;
            events <= '0;
            irq    <= '0;
        end else if (ring_rst) begin
            state            <= RS_IDLE;
            tmo_q            <= TICK_W'(MIN_TICKS);
            seen_q           <= '0;
            events           <= '0;
            events[EV_RESET] <= 1'b1;
            irq              <= '0;
        end else begin
            state  <= st_d;
            tmo_q  <= tmo_d;
            seen_q <= seen_q | vld_vec;
            events <= (events & ~ev_clr) | ev_set;
            irq    <= irq_d;
        end
    end

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state == RS_IDLE)); // R10

    AST_IDLE_NO_TIMERS: assert property (@(posedge clk) disable iff (rst)
        (state == RS_IDLE) |-> (run == '0)); // R1

    AST_NORMAL_FROM_FAULT: assert property (@(posedge clk) disable iff (rst)
        (state == RS_NORMAL && $past(state) != RS_NORMAL) |-> ($past(state) == RS_FAULT)); // R3

endmodule

// File: rtl/ring_beacon_monitor.sv
module ring_beacon_monitor
    import rbm_pkg::*;
#(
    parameter int TICK_DIV  = 1000,
    parameter int DEF_TICKS = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        ring_rst,
    input  logic [1:0]  bcn_vld,
    input  logic [1:0]  bcn_normal,
    input  logic [15:0] bcn_tmo_p0,
    input  logic [15:0] bcn_tmo_p1,
    input  logic [7:0]  ev_clr,
    output logic [1:0]  ring_state,
    output logic [7:0]  events,
    output logic [1:0]  timer_run,
    output logic [1:0]  irq
);
    logic                 tick;
    logic                 tmr_clr;
    logic [NUM_PORTS-1:0] load, expire;
    logic [TICK_W-1:0]    load_val;
    beacon_t              bcn [NUM_PORTS];
    ring_st_e             state;

    always_comb begin
        bcn[0] = '{vld: bcn_vld[0], normal: bcn_normal[0], tmo_us: bcn_tmo_p0};
        bcn[1] = '{vld: bcn_vld[1], normal: bcn_normal[1], tmo_us: bcn_tmo_p1};
    end

    rbm_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_tmr
        rbm_port_timer #(.DEF_TICKS(DEF_TICKS)) tmr_i (
            .clk      (clk),
            .rst      (rst),
            .clr      (tmr_clr),
            .tick     (tick),
            .load     (load[p]),
            .load_val (load_val),
            .running  (timer_run[p]),
            .expire   (expire[p])
        );
    end

    rbm_ring_fsm fsm_i (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .ring_rst (ring_rst),
        .bcn      (bcn),
        .ev_clr   (ev_clr),
        .run      (timer_run),
        .expire   (expire),
        .load     (load),
        .load_val (load_val),
        .tmr_clr  (tmr_clr),
        .state    (state),
        .events   (events),
        .irq      (irq)
    );

    assign ring_state = state;

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (|irq) |-> (ring_state != $past(ring_state) || (|events[7:6]))); // R8

endmodule

// File: tb/ring_beacon_monitor_tb_top.sv
module ring_beacon_monitor_tb_top;

    localparam int DIV = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        ring_rst = 1'b0;
    logic [1:0]  bcn_vld = '0;
    logic [1:0]  bcn_normal = '0;
    logic [15:0] bcn_tmo_p0 = '0;
    logic [15:0] bcn_tmo_p1 = '0;
    logic [7:0]  ev_clr = '0;
    logic [1:0]  ring_state;
    logic [7:0]  events;
    logic [1:0]  timer_run;
    logic [1:0]  irq;

    always #5 clk = ~clk;

    ring_beacon_monitor #(.TICK_DIV(DIV), .DEF_TICKS(20)) dut_i (
        .clk(clk), .rst(rst), .en(en), .ring_rst(ring_rst),
        .bcn_vld(bcn_vld), .bcn_normal(bcn_normal),
        .bcn_tmo_p0(bcn_tmo_p0), .bcn_tmo_p1(bcn_tmo_p1),
        .ev_clr(ev_clr), .ring_state(ring_state), .events(events),
        .timer_run(timer_run), .irq(irq)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string phase = "R1";

    // reference model state
    int m_pc = 0;
    int m_st = 0;
    int m_tmo = 20;
    int m_cnt [2];
    bit [1:0] m_run = '0;
    bit [1:0] m_seen = '0;
    bit [7:0] m_ev = '0;
    bit [1:0] m_irq = '0;

    function automatic int to_ticks(input int us);
        int t = us / 10;
        return (t < 20) ? 20 : t;
    endfunction

    task automatic model_step();
        bit tk;
        bit [1:0] exp_p;
        bit [1:0] ld;
        bit [7:0] nev;
        int nst;
        int ld_val;
        int lp;
        tk = (m_pc == DIV - 1);
        if (rst) begin
            m_pc = 0;
        end else begin
            m_pc = tk ? 0 : m_pc + 1;
        end
        if (rst || !en || ring_rst) begin
            m_st = 0; m_tmo = 20; m_run = '0; m_seen = '0; m_irq = '0;
            m_ev = (!rst && en && ring_rst) ? 8'h20 : 8'h00;
            return;
        end
        nev = m_ev & ~ev_clr;
        nst = m_st;
        ld = '0;
        ld_val = m_tmo;
        m_irq = '0;
        lp = bcn_vld[0] ? 0 : 1;
        if (bcn_vld != 0) begin
            if (m_st == 0) begin
                m_tmo = to_ticks(lp == 0 ? int'(bcn_tmo_p0) : int'(bcn_tmo_p1));
                ld_val = m_tmo;
                ld = 2'b11;
                nst = 1;
                nev[1] = 1'b1;
            end else begin
                ld = bcn_vld;
                if (m_st == 1 && bcn_normal[lp]) begin nst = 2; nev[0] = 1'b1; end
                if (m_st == 2 && !bcn_normal[lp]) begin nst = 1; nev[1] = 1'b1; end
            end
            if (nst != m_st) m_irq[lp] = 1'b1;
        end
        exp_p = '0;
        for (int p = 0; p < 2; p++) begin
            if (ld[p]) begin
                m_cnt[p] = ld_val; m_run[p] = 1'b1;
            end else if (m_run[p] && tk) begin
                m_cnt[p]--;
                if (m_cnt[p] == 0) begin
                    m_run[p] = 1'b0; exp_p[p] = 1'b1;
                end
            end
            if (bcn_vld[p] && !m_seen[p]) nev[3 + p] = 1'b1;
            if (exp_p[p]) begin nev[6 + p] = 1'b1; m_irq[p] = 1'b1; end
        end
        m_seen |= bcn_vld;
        if (exp_p != 0 && m_st == 2) begin nst = 1; nev[1] = 1'b1; end
        if (exp_p != 0 && m_run == 0) nev[2] = 1'b1;
        m_st = nst;
        m_ev = nev;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    task automatic step();
        model_step();
        @(posedge clk);
        #2;
        cycles++;
        chk(phase, "ring_state", int'(ring_state), m_st);
        chk(phase, "events", int'(events), int'(m_ev));
        chk(phase, "timer_run", int'(timer_run), int'(m_run));
        chk(phase, "irq", int'(irq), int'(m_irq));
    endtask

    task automatic idle_n(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic beacon(input bit [1:0] v, input bit [1:0] nrm, input int us0, input int us1);
        bcn_vld = v; bcn_normal = nrm;
        bcn_tmo_p0 = 16'(us0); bcn_tmo_p1 = 16'(us1);
        step();
        bcn_vld = '0;
    endtask

    // count cycles until timer_run[p] drops
    task automatic wait_expire(input int p, output int n);
        n = 0;
        while (timer_run[p] && n < 2000) begin
            step();
            n++;
        end
    endtask

    initial begin : watchdog
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int n;
        #2;
        phase = "R1";
        idle_n(3);
        chk("R1", "reset state idle", int'(ring_state), 0);
        chk("R1", "reset events", int'(events), 0);
        rst = 1'b0;
        en = 1'b1;
        idle_n(4);

        // first beacon: 405 us -> 40 ticks
        phase = "R2";
        beacon(2'b01, 2'b00, 405, 0);
        chk("R2", "state fault after first beacon", int'(ring_state), 1);
        chk("R2", "both timers running", int'(timer_run), 3);
        chk("R2", "fault transition bit", int'(events[1]), 1);
        chk("R7", "first beacon port0 bit", int'(events[3]), 1);
        idle_n(3);

        phase = "R3";
        beacon(2'b10, 2'b10, 900, 900);
        chk("R3", "state normal", int'(ring_state), 2);
        chk("R7", "first beacon port1 bit", int'(events[4]), 1);
        chk("R8", "irq on port1 state change", int'(irq), 2);

        phase = "R4";
        for (int k = 0; k < 6; k++) begin
            beacon(2'b11, 2'b11, 900, 900);
            idle_n(30 * DIV);
        end
        chk("R4", "no beacon lost", int'(events[7:6]), 0);
        chk("R4", "still normal", int'(ring_state), 2);

        phase = "R7";
        ev_clr = 8'hFF;
        step();
        ev_clr = 8'h00;
        chk("R7", "events cleared by W1C", int'(events), 0);

        // port1 goes silent, port0 keeps beaconing
        phase = "R6";
        beacon(2'b11, 2'b11, 0, 0);
        n = 0;
        while (timer_run[1] && n < 1000) begin
            if (n % (20 * DIV) == 0) beacon(2'b01, 2'b01, 0, 0); else step();
            n++;
        end
        chk("R5", "port1 expiry within 40-tick window", int'(n >= 39 * DIV && n <= 40 * DIV), 1);
        chk("R6", "lost port1", int'(events[7]), 1);
        chk("R6", "state fault after loss", int'(ring_state), 1);
        chk("R8", "irq port1 on expiry", int'(irq[1]), 1);
        wait_expire(0, n);
        chk("R6", "both stopped bit", int'(events[2]), 1);

        phase = "R9";
        ring_rst = 1'b1;
        step();
        ring_rst = 1'b0;
        chk("R9", "idle after ring reset", int'(ring_state), 0);
        chk("R9", "only reset bit", int'(events), 8'h20);

        // clamp: 50 us -> 20 ticks
        phase = "R5";
        beacon(2'b10, 2'b00, 0, 50);
        wait_expire(1, n);
        chk("R5", "clamped expiry window", int'(n >= 19 * DIV && n <= 20 * DIV), 1);
        ring_rst = 1'b1; step(); ring_rst = 1'b0;

        // simultaneous beacons: port0 timeout wins
        phase = "R11";
        beacon(2'b11, 2'b00, 300, 1000);
        wait_expire(0, n);
        chk("R11", "port0 timeout latched", int'(n >= 29 * DIV && n <= 30 * DIV), 1);
        beacon(2'b11, 2'b01, 0, 0);
        chk("R11", "port0 status decides", int'(ring_state), 2);
        // set and clear of the normal bit in the same cycle
        phase = "R7";
        beacon(2'b01, 2'b00, 0, 0);
        ev_clr = 8'h01;
        beacon(2'b01, 2'b01, 0, 0);
        ev_clr = 8'h00;
        chk("R7", "set wins over clear", int'(events[0]), 1);

        phase = "R10";
        en = 1'b0;
        step();
        beacon(2'b11, 2'b11, 500, 500);
        idle_n(3);
        chk("R10", "idle while disabled", int'(ring_state), 0);
        chk("R10", "events zero while disabled", int'(events), 0);
        chk("R10", "no timers while disabled", int'(timer_run), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule